// File: doc/BRIEF.md
# Clock Time Snapshot Shadow

This block keeps a shadow copy of a multi-field clock time (hundredths, seconds, minutes, hours, day, month) next to the live counters that produce it. A single enable bit in a small control register decides how the shadow behaves. While the enable is set, the shadow copies the whole live time on every clock edge. Once the enable is cleared, the shadow holds its last value. Software clears the enable to freeze the time, or the enable clears itself when a power-fail event arrives.

Software sets the enable, lets the shadow track the counters, and clears it just before it reads. Every field then comes from one sampled counter state, so the reader never has to check whether a rollover happened between two field reads. The shadow fields are also driven out as a flat vector for logic that wants them directly. Six low bits of the control register are plain storage for software. One bit is unimplemented and always reads as zero.

The live counters are outside this block. The bus is a simple single-cycle write strobe with a combinational read mux selected by the same address.

Top module: `rtc_time_snapshot`

## Requirements
- R1: After reset the control register reads 0x00 and every shadow field is 0.
- R2: A bus write to address 0 stores data bits 5:0 in control bits 5:0, and the written value reads back at address 0 from the next cycle.
- R3: Control bit 6 always reads 0, whatever value was written to it.
- R4: Control bit 7 is the save-enable. While it reads 1 at a clock edge, every shadow field takes the live field value present at that edge, so the shadow equals the live time of the previous cycle.
- R5: When a write to address 0 puts 0 in bit 7, the shadow holds the live time sampled at that write's edge, and stays unchanged while the enable remains 0.
- R6: A cycle in which pwrFail is high clears bit 7 at the following edge. The shadow holds the live time sampled at that edge.
- R7: If pwrFail is high in the same cycle as a write of 1 to bit 7, bit 7 ends at 0. Bits 5:0 of that write are still stored.
- R8: All shadow fields are loaded on the same edge from one live sample, so a frozen snapshot never mixes fields from different cycles.
- R9: Bus writes to any address other than 0 change neither the shadow fields nor the control register.
- R10: A read at address k, for k from 1 to 6, returns shadow field k-1: field 0 is hundredths in liveTime bits 7:0, then seconds, minutes, hours, day and month at rising byte positions. Reads at address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| liveTime | input | 48 | Live time fields, field 0 (hundredths) in the low byte |
| pwrFail | input | 1 | Power-fail event; clears the save-enable |
| busWr | input | 1 | Single-cycle write strobe |
| busAddr | input | 3 | Register address for writes and reads |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| snapTime | output | 48 | Shadow time fields, same layout as liveTime |

## Verification
All 256 control write values are swept, so storage of bits 5:0, loss of bit 6 and the save-enable are told apart bit by bit. The live time is driven with a pattern in which every field changes on every cycle, each field at its own rate. Tracking, freezing by a write and freezing by power fail then expose an off-by-one-cycle capture and a field taken from a different cycle. The bench also runs power fail together with a write that sets the enable, writes to every non-control address with tracking off, and a readback sweep over all addresses that shows any misrouted field.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  // Control register layout; bit positions are behaviour seen by software.
  localparam int CTRL_W      = 8;
  localparam int GP_W        = 6;
  localparam int RSVD_BIT    = 6;
  localparam int SAVE_EN_BIT = 7;

  // Strobes from control to datapath.
  typedef struct packed {
    logic follow;   // shadow loads the live time on this edge
  } snapStrobe_t;

endpackage

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import rtc_snap_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CTRL_W-1:0] busWrData,
  input  logic              pwrFail,
  output snapStrobe_t       strobe,
  output logic [CTRL_W-1:0] ctrlRd
);

  logic            ctrlWr;
  logic            saveEn;
  logic [GP_W-1:0] gpBits;

  assign ctrlWr = busWr && (busAddr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpBits <= '0;
      saveEn <= 1'b0;
    end else begin
      if (ctrlWr) gpBits <= busWrData[GP_W-1:0];
      // Power fail outranks a software write of the enable.
      if (pwrFail)     saveEn <= 1'b0;
      else if (ctrlWr) saveEn <= busWrData[SAVE_EN_BIT];
    end
  end

  always_comb begin
    ctrlRd                = '0;
    ctrlRd[GP_W-1:0]      = gpBits;
    ctrlRd[RSVD_BIT]      = 1'b0;
    ctrlRd[SAVE_EN_BIT]   = saveEn;
  end

  assign strobe.follow = saveEn;

  AST_PF_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> !ctrlRd[SAVE_EN_BIT]); // R6

  AST_PF_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrFail && ctrlWr && busWrData[SAVE_EN_BIT]) |=> (ctrlRd[SAVE_EN_BIT] == 1'b0)); // R7

  AST_GP_STORE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (ctrlRd[GP_W-1:0] == $past(busWrData[GP_W-1:0]))); // R2

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !pwrFail) |=> (ctrlRd[SAVE_EN_BIT] == $past(busWrData[SAVE_EN_BIT]))); // R4

endmodule

// File: rtl/snap_datapath.sv
module snap_datapath
  import rtc_snap_pkg::*;
#(
  parameter int NUM_FIELDS = 6,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  snapStrobe_t                    strobe,
  input  logic [NUM_FIELDS*DATA_W-1:0]   liveTime,
  input  logic [CTRL_W-1:0]              ctrlRd,
  input  logic [ADDR_W-1:0]              busAddr,
  output logic [NUM_FIELDS*DATA_W-1:0]   snapTime,
  output logic [DATA_W-1:0]              busRdData
);

  localparam int TOTAL_W = NUM_FIELDS * DATA_W;

  logic [DATA_W-1:0] shadow [NUM_FIELDS];

  // One register per field, all loaded by the same strobe on the same edge.
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              shadow[f] <= '0;
      else if (strobe.follow) shadow[f] <= liveTime[f*DATA_W +: DATA_W];
    end
    assign snapTime[f*DATA_W +: DATA_W] = shadow[f];
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == '0) busRdData = DATA_W'(ctrlRd);
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (busAddr == ADDR_W'(f + 1)) busRdData = shadow[f];
    end
  end

  AST_TRACK_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.follow |=> (snapTime == $past(liveTime))); // R4

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.follow |=> $stable(snapTime)); // R5

  AST_TOTAL_W: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr > ADDR_W'(NUM_FIELDS)) |-> (busRdData == '0)); // R10

  initial begin
    assert (TOTAL_W == $bits(snapTime));
  end

endmodule

// File: rtl/rtc_time_snapshot.sv
module rtc_time_snapshot
  import rtc_snap_pkg::*;
#(
  parameter int NUM_FIELDS = 6,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_FIELDS*DATA_W-1:0] liveTime,
  input  logic                         pwrFail,
  input  logic                         busWr,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWrData,
  output logic [DATA_W-1:0]            busRdData,
  output logic [NUM_FIELDS*DATA_W-1:0] snapTime
);

  localparam int ADDR_SPAN = NUM_FIELDS + 1;

  snapStrobe_t       strobe;
  logic [CTRL_W-1:0] ctrlRd;

  snap_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWrData (busWrData[CTRL_W-1:0]),
    .pwrFail   (pwrFail),
    .strobe    (strobe),
    .ctrlRd    (ctrlRd)
  );

  snap_datapath #(
    .NUM_FIELDS (NUM_FIELDS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .liveTime  (liveTime),
    .ctrlRd    (ctrlRd),
    .busAddr   (busAddr),
    .snapTime  (snapTime),
    .busRdData (busRdData)
  );

  initial begin
    assert ((1 << ADDR_W) >= ADDR_SPAN);
    assert (DATA_W >= CTRL_W);
  end

  AST_SHADOW_RO: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr != '0 && !strobe.follow) |=> $stable(snapTime)); // R9

  AST_CTRL_RO_ELSE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr != '0 && !pwrFail) |=> $stable(ctrlRd)); // R9

endmodule

// File: tb/test_rtc_time_snapshot.sv
module test_rtc_time_snapshot;

  localparam int NF = 6;
  localparam int DW = 8;
  localparam int AW = 3;

  logic            clk = 1'b0;
  logic            rstN;
  logic [NF*DW-1:0] liveTime;
  logic            pwrFail;
  logic            busWr;
  logic [AW-1:0]   busAddr;
  logic [DW-1:0]   busWrData;
  logic [DW-1:0]   busRdData;
  logic [NF*DW-1:0] snapTime;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  rtc_time_snapshot i_rtc_time_snapshot (
    .clk(clk), .rstN(rstN), .liveTime(liveTime), .pwrFail(pwrFail),
    .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .snapTime(snapTime)
  );

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] fieldAt(int n, int f);
    return DW'((n * (f + 3) + f * 17 + (n >> 2)) & 255);
  endfunction

  function automatic logic [NF*DW-1:0] timeAt(int n);
    logic [NF*DW-1:0] v;
    for (int f = 0; f < NF; f++) v[f*DW +: DW] = fieldAt(n, f);
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    busWr = 1'b1; busAddr = a; busWrData = d;
    step();
    busWr = 1'b0; busWrData = '0;
  endtask

  task automatic readAt(logic [AW-1:0] a, output logic [DW-1:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [DW-1:0] rd;
    logic [NF*DW-1:0] held;
    rstN = 1'b0; pwrFail = 1'b0; busWr = 1'b0; busAddr = '0; busWrData = '0;
    liveTime = timeAt(7);
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    readAt(0, rd);
    check("R1 ctrl", rd, 8'h00);
    check("R1 shadow", snapTime, '0);

    // R2 / R3 exhaustive control writes
    for (int d = 0; d < 256; d++) begin
      busWrite(0, DW'(d));
      readAt(0, rd);
      check("R2 ctrl readback", {rd[7], rd[5:0]}, {d[7], d[5:0]});
      check("R3 bit6 zero", rd[6], 1'b0);
    end

    // R4 tracking
    busWrite(0, 8'h80);
    for (int n = 1; n <= 20; n++) begin
      liveTime = timeAt(n);
      step();
      #1;
      check("R4 follow", snapTime, timeAt(n));
    end

    // R10 readback map while tracking stopped later; here sweep with live static
    for (int a = 0; a < 8; a++) begin
      readAt(AW'(a), rd);
      if (a == 0)       check("R10 addr0", rd, 8'h80);
      else if (a <= NF) check("R10 field", rd, fieldAt(20, a - 1));
      else              check("R10 unused addr", rd, 8'h00);
    end

    // R5 freeze by software write
    liveTime = timeAt(100);
    busWrite(0, 8'h00);
    #1;
    check("R5 freeze capture", snapTime, timeAt(100));
    for (int n = 101; n <= 110; n++) begin
      liveTime = timeAt(n);
      step();
      #1;
      check("R5 hold", snapTime, timeAt(100));
    end
    // R8 every field from the same sample
    for (int f = 0; f < NF; f++)
      check("R8 coherent field", snapTime[f*DW +: DW], fieldAt(100, f));

    // R6 power fail freeze
    busWrite(0, 8'h80);
    liveTime = timeAt(200);
    pwrFail = 1'b1;
    step();
    pwrFail = 1'b0;
    readAt(0, rd);
    check("R6 enable cleared", rd, 8'h00);
    check("R6 capture", snapTime, timeAt(200));
    for (int n = 201; n <= 205; n++) begin
      liveTime = timeAt(n);
      step();
      #1;
      check("R6 hold", snapTime, timeAt(200));
    end

    // R7 power fail with a write setting the enable
    pwrFail = 1'b1;
    busWrite(0, 8'hC5);
    pwrFail = 1'b0;
    readAt(0, rd);
    check("R7 enable stays 0", rd, 8'h05);
    liveTime = timeAt(300);
    step();
    #1;
    check("R7 shadow held", snapTime, timeAt(200));

    // R9 writes elsewhere do nothing
    held = snapTime;
    for (int a = 1; a < 8; a++) begin
      busWrite(AW'(a), DW'(a * 37 + 128));
      #1;
      check("R9 shadow unchanged", snapTime, held);
      readAt(0, rd);
      check("R9 ctrl unchanged", rd, 8'h05);
      readAt(AW'(a), rd);
      check("R9 readback", rd, (a <= NF) ? fieldAt(200, a - 1) : 8'h00);
    end

    finishRun();
  end

endmodule